// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital sequencer of an 8-bit successive-approximation converter. The search is built around an external DAC and comparator. A start-mode field selects which event starts a conversion. The event can be a software strobe, either of two timer overflows, a rising edge on an asynchronous external strobe, or a start request shared with a companion converter. Once a conversion starts, the block drives a trial code to the DAC. It then resolves one bit per step, from the most significant bit down, using the single comparator bit it reads back.

The time spent on each step comes from the system clock divided by a programmable count. At the end of a conversion the result register is loaded and a sticky completion flag is raised. The new result is also tested against two programmable limits. A match raises a separate sticky window flag. When the enable input is low the sequencer does nothing. All triggers are ignored, and a conversion already running is abandoned.

Top module: `sar_conv_ctrl`

## Requirements
- R1: With an ideal comparator (cmp_in = 1 when the analog input is at or above the trial code), the result equals the analog input code for every value from 0x00 to 0xFF.
- R2: While enable is 0, triggers are ignored and busy stays 0. Lowering enable during a conversion clears busy on the next edge, leaves result unchanged and does not set done_flag.
- R3: The first trial code of a conversion is 0x80. At each decision the bit under test is kept if cmp_in is 1 and cleared if it is 0, and the next lower bit is set.
- R4: Each bit decision takes clk_sel+1 clock cycles, using the clk_sel value captured at the start. busy is therefore 1 for exactly 8*(clk_sel+1) cycles, starting at the edge that accepts the trigger.
- R5: start_mode 3'b000 starts a conversion on a high cycle of sw_start.
- R6: start_mode 3'b001 starts on tmr_a_ovf and 3'b011 starts on tmr_b_ovf. Pulses on trigger inputs that are not selected have no effect.
- R7: start_mode 3'b010 starts on a rising edge of ext_start, which passes through two synchronizer flops and an edge detector. busy rises at the third clock edge after ext_start rises. Holding ext_start high does not start another conversion.
- R8: Any start_mode with bit 2 set (1xx) starts on a high cycle of peer_start.
- R9: A trigger that arrives while busy is 1 is ignored and does not extend or repeat the conversion.
- R10: result changes only at the edge that ends a conversion. It keeps the previous value while a conversion runs.
- R11: done_flag is set at the end of every completed conversion and stays set until a done_clr cycle. A set in the same cycle as a clear wins.
- R12: win_flag is set at the end of a conversion under one of two conditions. The first is lim_lo <= lim_hi and lim_lo <= result <= lim_hi. The second is lim_lo > lim_hi and (result <= lim_hi or result >= lim_lo). The flag is sticky until win_clr, and a set wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; 0 holds the block in shutdown |
| start_mode | input | 3 | Start-source select |
| clk_sel | input | 5 | Step divider; each decision takes clk_sel+1 clocks |
| lim_lo | input | 8 | Lower window limit (result at or above) |
| lim_hi | input | 8 | Upper window limit (result at or below) |
| sw_start | input | 1 | Software start strobe |
| tmr_a_ovf | input | 1 | First timer overflow pulse |
| ext_start | input | 1 | Asynchronous external start strobe |
| tmr_b_ovf | input | 1 | Second timer overflow pulse |
| peer_start | input | 1 | Start strobe shared with a companion converter |
| done_clr | input | 1 | Clears done_flag |
| win_clr | input | 1 | Clears win_flag |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above trial_code |
| trial_code | output | 8 | Code driven to the DAC |
| busy | output | 1 | 1 while a conversion runs |
| result | output | 8 | Last completed conversion result |
| done_flag | output | 1 | Sticky conversion-complete flag |
| win_flag | output | 1 | Sticky window-match flag |

## Verification
A wrong bit mask or a bad keep/clear decision shows at the ports as a result that differs from the modelled input. This appears at the edge that drops busy, which is 8*(clk_sel+1) cycles after the start. A divider fault shows as a busy length that is wrong by a multiple of 8 cycles. A fault in trigger selection or synchronization shows within three edges, as busy rising when it should not, or failing to rise. A stale window or done flag becomes visible in the cycle after a conversion ends.

// File: rtl/sar_pkg.sv
package sar_pkg;
   localparam int unsigned SAR_RES_W  = 8;
   localparam int unsigned SAR_DIV_W  = 5;
   localparam int unsigned SAR_MODE_W = 3;

   typedef enum logic [1:0] {
      SRC_SOFT  = 2'b00,
      SRC_TMR_A = 2'b01,
      SRC_EXT   = 2'b10,
      SRC_TMR_B = 2'b11
   } sar_src_e;
endpackage

// File: rtl/sar_trig_sel.sv
module sar_trig_sel #(
   parameter int unsigned MODE_W = sar_pkg::SAR_MODE_W,
   parameter int unsigned SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   input  logic              sw_start,
   input  logic              tmr_a_ovf,
   input  logic              ext_start,
   input  logic              tmr_b_ovf,
   input  logic              peer_start,
   output logic              trig
);
   import sar_pkg::*;

   localparam int unsigned CHAIN_W = SYNC_N + 1;

   if (MODE_W != 3) begin : g_bad_mode
      $error("sar_trig_sel: MODE_W must be 3");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("sar_trig_sel: SYNC_N must be at least 2");
   end

   // synchronizer stages followed by one history flop for edge detect
   logic [CHAIN_W-1:0] chain;
   logic               ext_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[CHAIN_W-2:0], ext_start};
   end

   assign ext_rise = chain[SYNC_N-1] & ~chain[SYNC_N];

   always_comb begin
      if (mode[MODE_W-1]) begin
         trig = peer_start;
      end else begin
         unique case (sar_src_e'(mode[1:0]))
            SRC_SOFT:  trig = sw_start;
            SRC_TMR_A: trig = tmr_a_ovf;
            SRC_EXT:   trig = ext_rise;
            SRC_TMR_B: trig = tmr_b_ovf;
            default:   trig = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/sar_search.sv
module sar_search #(
   parameter int unsigned RES_W = sar_pkg::SAR_RES_W,
   parameter int unsigned DIV_W = sar_pkg::SAR_DIV_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             start,
   input  logic [DIV_W-1:0] clk_sel,
   input  logic             cmp_in,
   output logic             busy,
   output logic [RES_W-1:0] trial,
   output logic             fin,
   output logic [RES_W-1:0] final_code
);
   localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

   if (RES_W < 2) begin : g_bad_res
      $error("sar_search: RES_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("sar_search: DIV_W must be at least 1");
   end

   logic [RES_W-1:0] code;
   logic [RES_W-1:0] mask;
   logic [DIV_W-1:0] div_cnt;
   logic [DIV_W-1:0] div_lim;
   logic             step_end;
   logic [RES_W-1:0] decided;

   assign step_end   = busy & enable & (div_cnt == div_lim);
   assign decided    = cmp_in ? code : (code & ~mask);
   assign fin        = step_end & mask[0];
   assign final_code = decided;
   assign trial      = code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         code    <= '0;
         mask    <= '0;
         div_cnt <= '0;
         div_lim <= '0;
      end else if (!busy) begin
         if (enable && start) begin
            busy    <= 1'b1;
            code    <= MSB_ONLY;
            mask    <= MSB_ONLY;
            div_cnt <= '0;
            div_lim <= clk_sel;
         end
      end else if (!enable) begin
         busy    <= 1'b0;
         mask    <= '0;
         div_cnt <= '0;
      end else if (step_end) begin
         div_cnt <= '0;
         mask    <= mask >> 1;
         if (mask[0]) begin
            busy <= 1'b0;
            code <= decided;
         end else begin
            code <= decided | (mask >> 1);
         end
      end else begin
         div_cnt <= div_cnt + 1'b1;
      end
   end

   a_r3_msb_first : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (trial == MSB_ONLY));
   a_r3_one_bit_under_test : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(mask) == 1));
   a_r4_divider_bound : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (div_cnt <= div_lim));
   a_r2_shutdown_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !busy);
endmodule

// File: rtl/sar_window.sv
module sar_window #(
   parameter int unsigned RES_W = sar_pkg::SAR_RES_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fin,
   input  logic [RES_W-1:0] code,
   input  logic [RES_W-1:0] lim_lo,
   input  logic [RES_W-1:0] lim_hi,
   input  logic             clr,
   output logic             flag
);
   logic above_lo;
   logic below_hi;
   logic hit;

   assign above_lo = (code >= lim_lo);
   assign below_hi = (code <= lim_hi);
   // ordered limits test the inside, swapped limits test the outside
   assign hit = (lim_lo <= lim_hi) ? (above_lo & below_hi) : (above_lo | below_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag <= 1'b0;
      else if (fin & hit) flag <= 1'b1;
      else if (clr)       flag <= 1'b0;
   end

   a_r12_hit_sets_flag : assert property (@(posedge clk) disable iff (!rst_n)
      (fin && hit) |=> flag);
   a_r12_flag_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
   parameter int unsigned RES_W  = sar_pkg::SAR_RES_W,
   parameter int unsigned DIV_W  = sar_pkg::SAR_DIV_W,
   parameter int unsigned MODE_W = sar_pkg::SAR_MODE_W,
   parameter int unsigned SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [MODE_W-1:0] start_mode,
   input  logic [DIV_W-1:0]  clk_sel,
   input  logic [RES_W-1:0]  lim_lo,
   input  logic [RES_W-1:0]  lim_hi,
   input  logic              sw_start,
   input  logic              tmr_a_ovf,
   input  logic              ext_start,
   input  logic              tmr_b_ovf,
   input  logic              peer_start,
   input  logic              done_clr,
   input  logic              win_clr,
   input  logic              cmp_in,
   output logic [RES_W-1:0]  trial_code,
   output logic              busy,
   output logic [RES_W-1:0]  result,
   output logic              done_flag,
   output logic              win_flag
);
   logic             trig;
   logic             fin;
   logic [RES_W-1:0] final_code;

   sar_trig_sel #(.MODE_W(MODE_W), .SYNC_N(SYNC_N)) u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (start_mode),
      .sw_start   (sw_start),
      .tmr_a_ovf  (tmr_a_ovf),
      .ext_start  (ext_start),
      .tmr_b_ovf  (tmr_b_ovf),
      .peer_start (peer_start),
      .trig       (trig)
   );

   sar_search #(.RES_W(RES_W), .DIV_W(DIV_W)) u_search (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .start      (trig),
      .clk_sel    (clk_sel),
      .cmp_in     (cmp_in),
      .busy       (busy),
      .trial      (trial_code),
      .fin        (fin),
      .final_code (final_code)
   );

   sar_window #(.RES_W(RES_W)) u_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .fin    (fin),
      .code   (final_code),
      .lim_lo (lim_lo),
      .lim_hi (lim_hi),
      .clr    (win_clr),
      .flag   (win_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result    <= '0;
         done_flag <= 1'b0;
      end else begin
         if (fin) result <= final_code;
         if (fin)           done_flag <= 1'b1;
         else if (done_clr) done_flag <= 1'b0;
      end
   end

   a_r10_result_held : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $stable(result));
   a_r11_done_on_finish : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && $past(enable) |-> done_flag);
   a_r11_done_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && !done_clr) |=> done_flag);
endmodule

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [2:0] start_mode = 3'b000;
   logic [4:0] clk_sel = 5'd0;
   logic [7:0] lim_lo = 8'h00;
   logic [7:0] lim_hi = 8'h00;
   logic       sw_start = 1'b0, tmr_a_ovf = 1'b0, ext_start = 1'b0;
   logic       tmr_b_ovf = 1'b0, peer_start = 1'b0;
   logic       done_clr = 1'b0, win_clr = 1'b0;
   logic [7:0] vin = 8'h00;
   logic       cmp_in;
   logic [7:0] trial_code, result;
   logic       busy, done_flag, win_flag;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;

   always #10 clk = ~clk;
   assign cmp_in = (vin >= trial_code);

   sar_conv_ctrl uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .start_mode(start_mode),
      .clk_sel(clk_sel), .lim_lo(lim_lo), .lim_hi(lim_hi),
      .sw_start(sw_start), .tmr_a_ovf(tmr_a_ovf), .ext_start(ext_start),
      .tmr_b_ovf(tmr_b_ovf), .peer_start(peer_start),
      .done_clr(done_clr), .win_clr(win_clr), .cmp_in(cmp_in),
      .trial_code(trial_code), .busy(busy), .result(result),
      .done_flag(done_flag), .win_flag(win_flag)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // 0 soft, 1 timer a, 2 timer b, 3 peer; one-cycle pulse
   task automatic pulse(input int src);
      @(negedge clk);
      case (src)
         0: sw_start = 1'b1;
         1: tmr_a_ovf = 1'b1;
         2: tmr_b_ovf = 1'b1;
         default: peer_start = 1'b1;
      endcase
      @(negedge clk);
      sw_start = 1'b0; tmr_a_ovf = 1'b0; tmr_b_ovf = 1'b0; peer_start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
   endtask

   task automatic clear_flags();
      @(negedge clk); done_clr = 1'b1; win_clr = 1'b1;
      @(negedge clk); done_clr = 1'b0; win_clr = 1'b0;
   endtask

   task automatic convert(input int src, input logic [7:0] v);
      vin = v;
      pulse(src);
      wait_idle();
   endtask

   task automatic t_reset();
      check("R11 reset done", done_flag, 0);
      check("R12 reset win", win_flag, 0);
      check("R4 reset busy", busy, 0);
      check("R10 reset result", result, 0);
   endtask

   task automatic t_soft_sweep();
      start_mode = 3'b000; clk_sel = 5'd0;
      for (int k = 0; k < 7; k++) begin
         logic [7:0] v;
         v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 :
             (k == 3) ? 8'h80 : (k == 4) ? 8'h7F : (k == 5) ? 8'h01 : 8'h5A;
         convert(0, v);
         check("R1 R5 soft result", result, v);
      end
      check("R11 done after soft", done_flag, 1);
   endtask

   task automatic t_trial_sequence();
      // input 0x5A: trials 80,40,60,50,58,5C,5A,5B
      int exp_tr [8] = '{8'h80, 8'h40, 8'h60, 8'h50, 8'h58, 8'h5C, 8'h5A, 8'h5B};
      start_mode = 3'b000; clk_sel = 5'd1; vin = 8'h5A;
      pulse(0);
      for (int s = 0; s < 8; s++) begin
         check("R3 trial code", trial_code, exp_tr[s]);
         @(negedge clk); @(negedge clk);
      end
      check("R3 final", result, 8'h5A);
   endtask

   task automatic t_busy_length(input logic [4:0] sel);
      int n = 0;
      start_mode = 3'b000; clk_sel = sel; vin = 8'h33;
      pulse(0);
      clk_sel = 5'd7; // change after capture must not matter
      while (busy && n < 2000) begin n++; @(negedge clk); end
      check("R4 busy length", n, 8 * (sel + 1));
   endtask

   task automatic t_timers();
      clk_sel = 5'd0;
      start_mode = 3'b001;
      pulse(2); pulse(0); pulse(3);
      check("R6 unselected sources ignored", busy, 0);
      convert(1, 8'h12);
      check("R6 timer a result", result, 8'h12);
      start_mode = 3'b011;
      pulse(1);
      check("R6 timer a ignored in b mode", busy, 0);
      convert(2, 8'hE7);
      check("R6 timer b result", result, 8'hE7);
   endtask

   task automatic t_ext();
      start_mode = 3'b010; clk_sel = 5'd0; vin = 8'h9C;
      pulse(0);
      check("R6 soft ignored in ext mode", busy, 0);
      @(negedge clk); ext_start = 1'b1;
      @(negedge clk); check("R7 not yet after 1 edge", busy, 0);
      @(negedge clk); check("R7 not yet after 2 edges", busy, 0);
      @(negedge clk); check("R7 start on third edge", busy, 1);
      wait_idle();
      check("R7 ext result", result, 8'h9C);
      repeat (10) @(negedge clk);
      check("R7 level held no retrigger", busy, 0);
      ext_start = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_peer();
      clk_sel = 5'd0;
      start_mode = 3'b100;
      convert(3, 8'h44);
      check("R8 peer 100 result", result, 8'h44);
      start_mode = 3'b111;
      pulse(0);
      check("R8 soft ignored in 111", busy, 0);
      convert(3, 8'hC3);
      check("R8 peer 111 result", result, 8'hC3);
   endtask

   task automatic t_disabled();
      start_mode = 3'b000; clear_flags();
      enable = 1'b0; vin = 8'h11;
      pulse(0);
      check("R2 no start when disabled", busy, 0);
      repeat (12) @(negedge clk);
      check("R2 result untouched", result, 8'hC3);
      check("R2 done untouched", done_flag, 0);
      // abort mid-conversion
      enable = 1'b1; clk_sel = 5'd3;
      pulse(0);
      repeat (5) @(negedge clk);
      check("R2 running before abort", busy, 1);
      enable = 1'b0;
      @(negedge clk);
      check("R2 abort clears busy", busy, 0);
      repeat (40) @(negedge clk);
      check("R2 abort keeps result", result, 8'hC3);
      check("R2 abort no done", done_flag, 0);
      enable = 1'b1;
   endtask

   task automatic t_retrigger_and_hold();
      int n = 0;
      start_mode = 3'b000; clk_sel = 5'd2; vin = 8'h6E;
      pulse(0);
      check("R10 previous result held", result, 8'hC3);
      repeat (3) @(negedge clk);
      vin = 8'h6E;
      pulse(0); // while busy
      n = 5;
      while (busy && n < 2000) begin n++; @(negedge clk); end
      check("R9 no extension", n, 24);
      repeat (3) @(negedge clk);
      check("R9 no repeat", busy, 0);
      check("R10 new result", result, 8'h6E);
   endtask

   task automatic t_done_sticky();
      clk_sel = 5'd0; start_mode = 3'b000;
      convert(0, 8'h20);
      repeat (20) @(negedge clk);
      check("R11 done sticky", done_flag, 1);
      @(negedge clk); done_clr = 1'b1;
      @(negedge clk); done_clr = 1'b0;
      check("R11 done cleared", done_flag, 0);
   endtask

   task automatic win_case(input logic [7:0] lo, input logic [7:0] hi,
                           input logic [7:0] v, input int exp);
      lim_lo = lo; lim_hi = hi;
      clear_flags();
      convert(0, v);
      check("R12 window flag", win_flag, exp);
   endtask

   task automatic t_window();
      start_mode = 3'b000; clk_sel = 5'd0;
      win_case(8'h40, 8'h80, 8'h40, 1);
      win_case(8'h40, 8'h80, 8'h80, 1);
      win_case(8'h40, 8'h80, 8'h3F, 0);
      win_case(8'h40, 8'h80, 8'h81, 0);
      win_case(8'hC0, 8'h20, 8'h20, 1);
      win_case(8'hC0, 8'h20, 8'h50, 0);
      win_case(8'hC0, 8'h20, 8'hC0, 1);
      win_case(8'h40, 8'h80, 8'h60, 1);
      convert(0, 8'h10);
      check("R12 flag sticky across miss", win_flag, 1);
      @(negedge clk); win_clr = 1'b1;
      @(negedge clk); win_clr = 1'b0;
      check("R12 flag cleared", win_flag, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      enable = 1'b1;
      t_soft_sweep();
      t_trial_sequence();
      t_busy_length(5'd0);
      t_busy_length(5'd3);
      t_busy_length(5'd31);
      t_timers();
      t_ext();
      t_peer();
      t_disabled();
      t_retrigger_and_hold();
      t_done_sticky();
      t_window();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule